// File: doc/BRIEF.md
# Programmable Tap Delay Line

This block delays a single-bit signal by a whole number of sample-clock cycles. A binary select word sets the delay. Each code step adds one cycle. A fixed pipeline latency comes before the programmable section, so the shortest delay is never zero.

The select word and an extra cascade bit pass through a load/hold register. While the load-enable input is low, the register follows the inputs on every clock. While it is high, the register keeps its contents and ignores the inputs. Two override inputs force the programmable delay to its minimum (zero taps) or its maximum (one tap beyond the all-ones code). If both are high, the minimum override wins. The latched cascade bit drives a true/complement output pair, so further delay stages can be chained. An output-disable input forces the delayed output low.

Top module: `tap_delay_line`

## Requirements
- R1: With both overrides low, the output after clock edge n equals the `din` value sampled at edge n − (FIX_LAT + code), where code is the latched select word read as an unsigned binary number with `sel[0]` as its least significant bit. Samples from before reset count as 0.
- R2: At each clock edge where `load_en` is low, the select register loads `sel` and `casc_in`. The new code governs the output computed at the following edge. While `load_en` is high, the register keeps its contents, and changes on `sel` and `casc_in` have no effect on `dout`, `casc_p` or `casc_n`.
- R3: When `set_min` is high at an edge, the output computed at that edge uses zero programmable taps (a delay of FIX_LAT), whatever code is latched. While `set_min` is high, `casc_p` is 0 and `casc_n` is 1.
- R4: When `set_max` is high and `set_min` is low, the programmable delay is 2^SEL_W taps (1024 by default), one more than the all-ones code. While this holds, `casc_p` is 1 and `casc_n` is 0.
- R5: When `set_min` and `set_max` are both high, the block behaves exactly as with `set_min` alone, for both the delay and the cascade pair.
- R6: When `out_dis` is high at an edge, `dout` is 0 after that edge. The delay history keeps filling, so once `out_dis` returns low, the output again follows R1 at once.
- R7: With both overrides low, `casc_p` equals the latched cascade bit and `casc_n` is its complement.
- R8: A synchronous reset clears the delay history, the output, the latched code and the latched cascade bit. During and after reset, `dout` is 0 and `casc_p`/`casc_n` are 0/1.
- R9: At code 0 the total delay is exactly FIX_LAT cycles (default 2). At code 1023 it is FIX_LAT + 1023 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Signal to be delayed |
| sel | input | SEL_W | Delay select code, bit 0 is the LSB |
| casc_in | input | 1 | Cascade control bit, latched with `sel` |
| load_en | input | 1 | Low: select register follows inputs; high: hold |
| set_min | input | 1 | Force zero programmable taps (highest priority) |
| set_max | input | 1 | Force 2^SEL_W programmable taps |
| out_dis | input | 1 | High forces `dout` low |
| dout | output | 1 | Delayed signal, registered |
| casc_p | output | 1 | Cascade output, true polarity |
| casc_n | output | 1 | Cascade output, complement polarity |

## Verification
`dout` is registered. After edge n it reflects the `din` sampled FIX_LAT + taps edges earlier. The tap count comes from the overrides sampled at edge n and the code latched at edge n−1 or before. A select change while `load_en` is low therefore first affects the output one edge after it is loaded. The cascade pair changes just after the edge that latches `casc_in`, and it responds to the overrides with no clock at all. The bench steps a behavioural model on every rising edge, keeping the full history of `din` samples in a queue. It compares `dout`, `casc_p` and `casc_n` on every falling edge, before new inputs are applied, so each result is read in the cycle it is due.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    // Source of the programmable tap count
    typedef enum logic [1:0] {
        TAP_FROM_CODE = 2'd0,
        TAP_FORCE_MIN = 2'd1,
        TAP_FORCE_MAX = 2'd2
    } tap_src_e;

endpackage

// File: rtl/tdl_select_reg.sv
module tdl_select_reg #(
    parameter int SEL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             casc_in,
    output logic [SEL_W-1:0] code_o,
    output logic             casc_o
);

    typedef struct packed {
        logic [SEL_W-1:0] code;
        logic             casc;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (!load_en) begin
            st_d.code = sel_in;
            st_d.casc = casc_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign casc_o = st_q.casc;

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        load_en |=> ($stable(code_o) && $stable(casc_o))); // R2

    AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> (code_o == $past(sel_in) && casc_o == $past(casc_in))); // R2

endmodule

// File: rtl/tdl_tap_ctrl.sv
module tdl_tap_ctrl #(
    parameter int SEL_W = 10
) (
    input  logic             set_min,
    input  logic             set_max,
    input  logic [SEL_W-1:0] code,
    input  logic             casc_lat,
    output logic [SEL_W:0]   taps,
    output logic             casc_p,
    output logic             casc_n
);
    import tdl_pkg::*;

    localparam int TAP_W = SEL_W + 1;
    localparam logic [TAP_W-1:0] MAX_TAPS = TAP_W'(1) << SEL_W;

    tap_src_e src;

    // Minimum override outranks maximum override, both outrank the code
    always_comb begin
        if (set_min)      src = TAP_FORCE_MIN;
        else if (set_max) src = TAP_FORCE_MAX;
        else              src = TAP_FROM_CODE;
    end

    always_comb begin
        unique case (src)
            TAP_FORCE_MIN: begin
                taps   = '0;
                casc_p = 1'b0;
            end
            TAP_FORCE_MAX: begin
                taps   = MAX_TAPS;
                casc_p = 1'b1;
            end
            default: begin
                taps   = {1'b0, code};
                casc_p = casc_lat;
            end
        endcase
        casc_n = ~casc_p;
    end

endmodule

// File: rtl/tdl_shift_line.sv
module tdl_shift_line #(
    parameter int SEL_W   = 10,
    parameter int FIX_LAT = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           din,
    input  logic [SEL_W:0] taps,
    input  logic           out_dis,
    output logic           dout
);
    localparam int MAX_TAPS = 1 << SEL_W;
    localparam int DEPTH    = MAX_TAPS + FIX_LAT;
    localparam int IDX_W    = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0] hist;
        logic             out;
    } line_state_t;

    line_state_t      ln_d, ln_q;
    logic [IDX_W-1:0] tap_idx;

    // hist[i] holds the sample taken i edges before the most recent one
    assign tap_idx = IDX_W'(FIX_LAT - 1) + IDX_W'(taps);

    always_comb begin
        ln_d = ln_q;
        if (rst) begin
            ln_d = '0;
        end else begin
            ln_d.hist = {ln_q.hist[DEPTH-2:0], din};
            ln_d.out  = out_dis ? 1'b0 : ln_q.hist[tap_idx];
        end
    end

    always_ff @(posedge clk) begin
        ln_q <= ln_d;
    end

    assign dout = ln_q.out;

    AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (rst)
        out_dis |=> !dout); // R6

    AST_HIST_SHIFTS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ln_q.hist[0] == $past(din)); // R1

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
    parameter int SEL_W   = 10,
    parameter int FIX_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    input  logic             casc_in,
    input  logic             load_en,
    input  logic             set_min,
    input  logic             set_max,
    input  logic             out_dis,
    output logic             dout,
    output logic             casc_p,
    output logic             casc_n
);

    logic [SEL_W-1:0] code_lat;
    logic             casc_lat;
    logic [SEL_W:0]   taps;

    tdl_select_reg #(.SEL_W(SEL_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .sel_in  (sel),
        .casc_in (casc_in),
        .code_o  (code_lat),
        .casc_o  (casc_lat)
    );

    tdl_tap_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .set_min  (set_min),
        .set_max  (set_max),
        .code     (code_lat),
        .casc_lat (casc_lat),
        .taps     (taps),
        .casc_p   (casc_p),
        .casc_n   (casc_n)
    );

    tdl_shift_line #(.SEL_W(SEL_W), .FIX_LAT(FIX_LAT)) u_line (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .taps    (taps),
        .out_dis (out_dis),
        .dout    (dout)
    );

    AST_MIN_CASC_LOW: assert property (@(posedge clk) disable iff (rst)
        set_min |-> (!casc_p && casc_n)); // R3

    AST_MAX_CASC_HIGH: assert property (@(posedge clk) disable iff (rst)
        (set_max && !set_min) |-> (casc_p && !casc_n)); // R4

    AST_CASC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ($past(!load_en) && !set_min && !set_max) |-> (casc_p == $past(casc_in))); // R7

endmodule

// File: tb/tap_delay_line_bench.sv
module tap_delay_line_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SEL_W      = 10;
    localparam int FIX_LAT    = 2;
    localparam int MAX_TAPS   = 1 << SEL_W;

    logic             clk = 1'b0;
    logic             rst;
    logic             din;
    logic [SEL_W-1:0] sel;
    logic             casc_in;
    logic             load_en;
    logic             set_min;
    logic             set_max;
    logic             out_dis;
    logic             dout;
    logic             casc_p;
    logic             casc_n;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string tag      = "R8";

    // Reference model state
    bit q_hist[$];
    int m_code = 0;
    bit m_casc = 1'b0;
    bit m_dout = 1'b0;

    tap_delay_line #(.SEL_W(SEL_W), .FIX_LAT(FIX_LAT)) u_tap_delay_line (
        .clk(clk), .rst(rst), .din(din), .sel(sel), .casc_in(casc_in),
        .load_en(load_en), .set_min(set_min), .set_max(set_max),
        .out_dis(out_dis), .dout(dout), .casc_p(casc_p), .casc_n(casc_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            q_hist.delete();
            m_code = 0;
            m_casc = 1'b0;
            m_dout = 1'b0;
        end else begin
            int taps;
            int idx;
            q_hist.push_back(din);
            taps = set_min ? 0 : (set_max ? MAX_TAPS : m_code);
            idx  = q_hist.size() - 1 - (FIX_LAT + taps);
            m_dout = out_dis ? 1'b0 : ((idx >= 0) ? q_hist[idx] : 1'b0);
            if (!load_en) begin
                m_code = int'(sel);
                m_casc = casc_in;
            end
        end
    end

    task automatic check_outputs();
        bit e_cp;
        e_cp = set_min ? 1'b0 : (set_max ? 1'b1 : m_casc);
        n_checks++;
        if (dout !== m_dout) begin
            n_fail++;
            $display("FAIL %s dout actual=%b expected=%b at %0t", tag, dout, m_dout, $time);
        end
        n_checks++;
        if (casc_p !== e_cp || casc_n !== ~e_cp) begin
            n_fail++;
            $display("FAIL %s cascade actual=%b/%b expected=%b/%b at %0t",
                     tag, casc_p, casc_n, e_cp, ~e_cp, $time);
        end
    endtask

    // One cycle: check at falling edge, then apply new random data
    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check_outputs();
            din = 1'($urandom);
        end
    endtask

    task automatic load_code(input int code, input bit cb);
        @(negedge clk);
        check_outputs();
        load_en = 1'b0;
        sel     = SEL_W'(code);
        casc_in = cb;
        din     = 1'($urandom);
        @(negedge clk);
        check_outputs();
        load_en = 1'b1;
        din     = 1'($urandom);
    endtask

    initial begin
        rst = 1'b1; din = 1'b0; sel = '0; casc_in = 1'b0; load_en = 1'b0;
        set_min = 1'b0; set_max = 1'b0; out_dis = 1'b0;
        tag = "R8";
        run(4);
        rst = 1'b0;

        tag = "R9";  load_code(0, 1'b0);    run(40);
        tag = "R1";  load_code(1, 1'b1);    run(40);
        tag = "R1";  load_code(37, 1'b0);   run(120);
        tag = "R9";  load_code(1023, 1'b1); run(2100);
        tag = "R2";  load_code(5, 1'b0);
        sel = 10'd700; casc_in = 1'b1;      run(60);
        sel = 10'd3;                        run(30);
        tag = "R2";  load_en = 1'b0;        run(30);
        sel = 10'd9;                        run(30);
        tag = "R7";  casc_in = 1'b0;        run(5);
        casc_in = 1'b1;                     run(5);
        load_en = 1'b1;
        tag = "R4";  set_max = 1'b1;        run(2200);
        tag = "R5";  set_min = 1'b1;        run(60);
        tag = "R3";  set_max = 1'b0;        run(60);
        set_min = 1'b0;
        tag = "R6";  load_code(12, 1'b0);   run(30);
        out_dis = 1'b1;                     run(40);
        out_dis = 1'b0;                     run(40);
        tag = "R8";  rst = 1'b1;            run(3);
        rst = 1'b0;                         run(20);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule